// File: doc/BRIEF.md
# CAN Acceptance Filter Bank Array

This block sits beside a CAN receiver. For every received frame identifier it decides whether the frame is kept and, if so, which of two receive FIFOs takes it. There are fourteen banks. Each bank holds two 32-bit filter words and four control bits: enable, layout (one 32-bit filter or a pair of 16-bit filters), mode (exact identifier list or identifier plus mask) and FIFO routing.

Software sets the banks up through a word-addressed write port with a combinational read port. A global configuration bit guards the layout, mode and routing bits. The filter words of a bank can change only while that bank is disabled or while the configuration bit is set. The receiver presents an identifier with its extended-format and remote-request flags, plus a one-cycle strobe. One clock later the block returns the accept decision, the FIFO select and the index of the filter that matched. When several filters match, the lowest index wins.

Top module: `can_accept_filter`

## Requirements
- R1: After reset every register reads back as zero and the outputs hit_valid, hit_accept, hit_fifo and hit_index are zero.
- R2: Register map (word addresses):
  - 0: bit 0 is the configuration bit.
  - 1: per-bank layout bits.
  - 2: per-bank mode bits.
  - 3: per-bank FIFO bits.
  - 4: per-bank enable bits.
  - 16+2b: filter word 1 of bank b.
  - 17+2b: filter word 2 of bank b.
  
  In the per-bank registers, bit b belongs to bank b. Bits above the bank count, and every unmapped address, read zero and ignore writes.
- R3: Writes to the layout, mode and FIFO registers take effect only while the configuration bit is 1. Otherwise they are ignored.
- R4: A write to a filter word takes effect only while that bank's enable bit is 0 or the configuration bit is 1. Otherwise it is ignored.
- R5: A bank whose enable bit is 0 never matches.
- R6: Layout bit 1 makes the bank one 32-bit filter, and the frame is compared as the 32-bit value:
  - bits 31:21 hold the standard identifier (ID[28:18] for extended frames);
  - bits 20:3 hold extended ID[17:0];
  - bit 2 is the extended flag and bit 1 is the remote flag;
  - bit 0 is never compared.
  
  With mode bit 1 (list), word 1 and word 2 are two identifiers and must match exactly. They are slots 0 and 1.
- R7: In 32-bit layout with mode bit 0 (mask), word 1 is the identifier and word 2 is the mask. Only positions whose mask bit is 1 are compared. This is slot 0.
- R8: Layout bit 0 makes the bank two 16-bit halves per word, and the frame is compared as the 16-bit value:
  - bits 15:5 hold the standard identifier;
  - bit 4 is the remote flag and bit 3 is the extended flag;
  - bits 2:0 hold extended ID[17:15].
  
  In list mode the four identifiers are word1[15:0], word1[31:16], word2[15:0] and word2[31:16], as slots 0 to 3. In mask mode, word1 is {mask, id} as slot 0 and word2 is {mask, id} as slot 1.
- R9: For a standard frame, the extended-identifier positions (bits 20:3 in 32-bit form, bits 2:0 in 16-bit form) are not compared. A standard frame's identifier is ID[10:0].
- R10: The reported index is 4*bank+slot. When several filters match, the lowest bank wins, and within that bank the lowest slot wins.
- R11: hit_fifo equals the FIFO bit of the winning bank.
- R12: The results are registered. hit_valid is frm_valid delayed one clock, and hit_accept, hit_fifo and hit_index refer to the identifier sampled on that same edge. hit_fifo and hit_index are zero whenever hit_accept is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| frm_valid | input | 1 | Identifier strobe |
| frm_id | input | 29 | Received identifier (standard in bits 10:0) |
| frm_ext | input | 1 | Extended-format flag |
| frm_rtr | input | 1 | Remote-request flag |
| hit_valid | output | 1 | Result strobe, one clock after frm_valid |
| hit_accept | output | 1 | Frame accepted |
| hit_fifo | output | 1 | Target FIFO of the accepted frame |
| hit_index | output | IDX_W | Index of the filter that matched |

## Verification
The decision for an identifier presented with frm_valid is due on the first rising edge after it. Configuration writes change the register state on the edge that samples them, and read data follows reg_addr combinationally. The reference model therefore computes its expected decision from its pre-edge register copy at each rising edge, and only then applies the write. It compares all outputs and the read data 1 ns after that edge, before any input moves on the next falling edge. The directed checks send an identifier on one falling edge, drop the strobe on the next falling edge and sample 1 ns later, which lands exactly in the result cycle.

// File: rtl/can_accept_filter.sv
`timescale 1ns/1ps
module can_accept_filter #(
  parameter int NUM_BANKS = 14,
  parameter int ADDR_W    = 6,
  localparam int IDX_W    = $clog2(NUM_BANKS * 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              frm_valid,
  input  logic [28:0]       frm_id,
  input  logic              frm_ext,
  input  logic              frm_rtr,
  output logic              hit_valid,
  output logic              hit_accept,
  output logic              hit_fifo,
  output logic [IDX_W-1:0]  hit_index
);
  localparam int WORD_BASE = 16;

  logic                 cfg_q;
  logic [NUM_BANKS-1:0] width_q, mode_q, fifo_q, en_q;
  logic [31:0]          w1_q [NUM_BANKS];
  logic [31:0]          w2_q [NUM_BANKS];

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= 1'b0;
      width_q <= '0;
      mode_q  <= '0;
      fifo_q  <= '0;
      en_q    <= '0;
    end else if (reg_we) begin
      case (int'(reg_addr))
        0: cfg_q <= reg_wdata[0];
        1: if (cfg_q) width_q <= reg_wdata[NUM_BANKS-1:0];
        2: if (cfg_q) mode_q  <= reg_wdata[NUM_BANKS-1:0];
        3: if (cfg_q) fifo_q  <= reg_wdata[NUM_BANKS-1:0];
        4: en_q <= reg_wdata[NUM_BANKS-1:0];
        default: ;
      endcase
    end
  end

  // filter words, guarded per bank
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        w1_q[b] <= '0;
        w2_q[b] <= '0;
      end
    end else if (reg_we) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (cfg_q || !en_q[b]) begin
          if (int'(reg_addr) == WORD_BASE + 2*b)     w1_q[b] <= reg_wdata;
          if (int'(reg_addr) == WORD_BASE + 2*b + 1) w2_q[b] <= reg_wdata;
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (int'(reg_addr))
      0: reg_rdata[0] = cfg_q;
      1: reg_rdata[NUM_BANKS-1:0] = width_q;
      2: reg_rdata[NUM_BANKS-1:0] = mode_q;
      3: reg_rdata[NUM_BANKS-1:0] = fifo_q;
      4: reg_rdata[NUM_BANKS-1:0] = en_q;
      default: ;
    endcase
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (int'(reg_addr) == WORD_BASE + 2*b)     reg_rdata = w1_q[b];
      if (int'(reg_addr) == WORD_BASE + 2*b + 1) reg_rdata = w2_q[b];
    end
  end

  // frame in both comparison layouts
  wire [10:0] std_id = frm_ext ? frm_id[28:18] : frm_id[10:0];
  wire [31:0] fw32   = frm_ext ? {frm_id, 1'b1, frm_rtr, 1'b0}
                               : {std_id, 18'd0, 1'b0, frm_rtr, 1'b0};
  wire [31:0] care32 = frm_ext ? 32'hFFFF_FFFE : 32'hFFE0_0006;
  wire [15:0] fw16   = {std_id, frm_rtr, frm_ext, frm_ext ? frm_id[17:15] : 3'd0};
  wire [15:0] care16 = frm_ext ? 16'hFFFF : 16'hFFF8;

  function automatic logic eq32(logic [31:0] a, logic [31:0] f, logic [31:0] c);
    return ((a ^ f) & c) == '0;
  endfunction

  function automatic logic eq16(logic [15:0] a, logic [15:0] f, logic [15:0] c);
    return ((a ^ f) & c) == '0;
  endfunction

  logic [3:0]       slot_hit [NUM_BANKS];
  logic             any_hit;
  logic             sel_fifo;
  logic [IDX_W-1:0] sel_idx;

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (width_q[b]) begin
        if (mode_q[b])
          slot_hit[b] = {2'b00, eq32(fw32, w2_q[b], care32), eq32(fw32, w1_q[b], care32)};
        else
          slot_hit[b] = {3'b000, eq32(fw32, w1_q[b], care32 & w2_q[b])};
      end else begin
        if (mode_q[b])
          slot_hit[b] = {eq16(fw16, w2_q[b][31:16], care16), eq16(fw16, w2_q[b][15:0], care16),
                         eq16(fw16, w1_q[b][31:16], care16), eq16(fw16, w1_q[b][15:0], care16)};
        else
          slot_hit[b] = {2'b00, eq16(fw16, w2_q[b][15:0], care16 & w2_q[b][31:16]),
                         eq16(fw16, w1_q[b][15:0], care16 & w1_q[b][31:16])};
      end
      slot_hit[b] = slot_hit[b] & {4{en_q[b]}};
    end
    any_hit  = 1'b0;
    sel_fifo = 1'b0;
    sel_idx  = '0;
    for (int b = NUM_BANKS - 1; b >= 0; b--) begin
      for (int s = 3; s >= 0; s--) begin
        if (slot_hit[b][s]) begin
          any_hit  = 1'b1;
          sel_fifo = fifo_q[b];
          sel_idx  = IDX_W'(b * 4 + s);
        end
      end
    end
  end

  wire take = frm_valid && any_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_valid  <= 1'b0;
      hit_accept <= 1'b0;
      hit_fifo   <= 1'b0;
      hit_index  <= '0;
    end else begin
      hit_valid  <= frm_valid;
      hit_accept <= take;
      hit_fifo   <= take ? sel_fifo : 1'b0;
      hit_index  <= take ? sel_idx : '0;
    end
  end
endmodule

// File: rtl/can_accept_filter_chk.sv
`timescale 1ns/1ps
module can_accept_filter_chk #(
  parameter int NUM_BANKS = 14,
  parameter int ADDR_W    = 6,
  localparam int IDX_W    = $clog2(NUM_BANKS * 4)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_we,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic                 frm_valid,
  input logic                 hit_valid,
  input logic                 hit_accept,
  input logic                 hit_fifo,
  input logic [IDX_W-1:0]     hit_index,
  input logic                 cfg_q,
  input logic [NUM_BANKS-1:0] width_q,
  input logic [NUM_BANKS-1:0] mode_q,
  input logic [NUM_BANKS-1:0] fifo_q,
  input logic [NUM_BANKS-1:0] en_q
);
  logic [NUM_BANKS-1:0] en_d, fifo_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d   <= '0;
      fifo_d <= '0;
    end else begin
      en_d   <= en_q;
      fifo_d <= fifo_q;
    end
  end

  wire ctl_addr = (int'(reg_addr) >= 1) && (int'(reg_addr) <= 3);
  wire [IDX_W-3:0] win_bank = hit_index[IDX_W-1:2];

  p_ctl_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !cfg_q && ctl_addr) |=> ($stable(width_q) && $stable(mode_q) && $stable(fifo_q)));

  p_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && en_q == '0) |=> !hit_accept);

  p_bank_enabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hit_accept |-> en_d[win_bank]);

  p_fifo_route_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hit_accept |-> (hit_fifo == fifo_d[win_bank]));

  p_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> hit_valid);

  p_no_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> !hit_valid);

  p_accept_qual_r12: assert property (@(posedge clk) disable iff (!rst_n)
    hit_accept |-> hit_valid);

  p_idle_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_accept |-> (hit_fifo == 1'b0 && hit_index == '0));
endmodule

bind can_accept_filter can_accept_filter_chk #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .frm_valid(frm_valid),
  .hit_valid(hit_valid), .hit_accept(hit_accept), .hit_fifo(hit_fifo), .hit_index(hit_index),
  .cfg_q(cfg_q), .width_q(width_q), .mode_q(mode_q), .fifo_q(fifo_q), .en_q(en_q)
);

// File: tb/test_can_accept_filter.sv
`timescale 1ns/1ps
module test_can_accept_filter;
  localparam int NB = 14;
  localparam int AW = 6;
  localparam int IW = $clog2(NB * 4);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          frm_valid = 1'b0;
  logic [28:0]   frm_id = '0;
  logic          frm_ext = 1'b0;
  logic          frm_rtr = 1'b0;
  logic          hit_valid, hit_accept, hit_fifo;
  logic [IW-1:0] hit_index;

  always #2.5 clk = ~clk;

  can_accept_filter #(.NUM_BANKS(NB), .ADDR_W(AW)) i_can_accept_filter (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .frm_valid(frm_valid), .frm_id(frm_id), .frm_ext(frm_ext),
    .frm_rtr(frm_rtr), .hit_valid(hit_valid), .hit_accept(hit_accept), .hit_fifo(hit_fifo),
    .hit_index(hit_index));

  int total = 0;
  int bad = 0;
  bit done = 0;

  task automatic check(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  bit        m_cfg;
  bit [31:0] m_width, m_mode, m_fifo, m_en;
  bit [31:0] m_w1 [NB];
  bit [31:0] m_w2 [NB];
  bit        e_valid, e_acc, e_fifo;
  int        e_idx;

  function automatic bit [31:0] mk32(bit [28:0] id, bit ext, bit rtr);
    bit [31:0] v;
    if (ext) v = (32'(id) << 3) | 32'h4;
    else     v = 32'(id[10:0]) << 21;
    if (rtr) v = v | 32'h2;
    return v;
  endfunction

  function automatic bit [15:0] mk16(bit [28:0] id, bit ext, bit rtr);
    bit [15:0] v;
    if (ext) v = (16'(id[28:18]) << 5) | 16'h8 | 16'(id[17:15]);
    else     v = 16'(id[10:0]) << 5;
    if (rtr) v = v | 16'h10;
    return v;
  endfunction

  function automatic bit same(bit [31:0] a, bit [31:0] f, bit [31:0] care, int n);
    for (int i = 0; i < n; i++)
      if (care[i] && (a[i] != f[i])) return 0;
    return 1;
  endfunction

  function automatic int ref_eval(bit [28:0] id, bit ext, bit rtr);
    bit [31:0] v32 = mk32(id, ext, rtr);
    bit [31:0] v16 = 32'(mk16(id, ext, rtr));
    bit [31:0] c32 = ext ? 32'hFFFF_FFFE : 32'hFFE0_0006;
    bit [31:0] c16 = ext ? 32'hFFFF : 32'hFFF8;
    bit [31:0] h [4];
    for (int b = 0; b < NB; b++) begin
      if (!m_en[b]) continue;
      if (m_width[b]) begin
        if (m_mode[b]) begin
          if (same(v32, m_w1[b], c32, 32)) return 4*b;
          if (same(v32, m_w2[b], c32, 32)) return 4*b + 1;
        end else if (same(v32, m_w1[b], c32 & m_w2[b], 32)) return 4*b;
      end else begin
        h[0] = 32'(m_w1[b][15:0]);  h[1] = 32'(m_w1[b][31:16]);
        h[2] = 32'(m_w2[b][15:0]);  h[3] = 32'(m_w2[b][31:16]);
        if (m_mode[b]) begin
          for (int s = 0; s < 4; s++)
            if (same(v16, h[s], c16, 16)) return 4*b + s;
        end else begin
          if (same(v16, h[0], c16 & h[1], 16)) return 4*b;
          if (same(v16, h[2], c16 & h[3], 16)) return 4*b + 1;
        end
      end
    end
    return -1;
  endfunction

  function automatic bit [31:0] ref_read(int a);
    if (a == 0) return 32'(m_cfg);
    if (a == 1) return m_width;
    if (a == 2) return m_mode;
    if (a == 3) return m_fifo;
    if (a == 4) return m_en;
    for (int b = 0; b < NB; b++) begin
      if (a == 16 + 2*b) return m_w1[b];
      if (a == 17 + 2*b) return m_w2[b];
    end
    return 0;
  endfunction

  bit [31:0] bank_mask = (32'd1 << NB) - 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg = 0; m_width = 0; m_mode = 0; m_fifo = 0; m_en = 0;
      for (int b = 0; b < NB; b++) begin m_w1[b] = 0; m_w2[b] = 0; end
      e_valid = 0; e_acc = 0; e_fifo = 0; e_idx = 0;
    end else begin
      int r;
      int a;
      r = ref_eval(frm_id, frm_ext, frm_rtr);
      e_valid = frm_valid;
      e_acc   = frm_valid && (r >= 0);
      e_idx   = e_acc ? r : 0;
      e_fifo  = e_acc ? m_fifo[r / 4] : 1'b0;
      if (reg_we) begin
        a = int'(reg_addr);
        if (a == 0) m_cfg = reg_wdata[0];
        if (a == 1 && m_cfg) m_width = reg_wdata & bank_mask;
        if (a == 2 && m_cfg) m_mode  = reg_wdata & bank_mask;
        if (a == 3 && m_cfg) m_fifo  = reg_wdata & bank_mask;
        if (a == 4) m_en = reg_wdata & bank_mask;
        for (int b = 0; b < NB; b++) begin
          if (m_cfg || !m_en[b]) begin
            if (a == 16 + 2*b) m_w1[b] = reg_wdata;
            if (a == 17 + 2*b) m_w2[b] = reg_wdata;
          end
        end
      end
    end
    #1;
    check(hit_valid == e_valid, "R12 hit_valid", hit_valid, e_valid);
    check(hit_accept == e_acc, "R6 R7 R8 R9 hit_accept", hit_accept, e_acc);
    check(hit_fifo == e_fifo, "R11 hit_fifo", hit_fifo, e_fifo);
    check(int'(hit_index) == e_idx, "R10 hit_index", hit_index, e_idx);
    check(reg_rdata == ref_read(int'(reg_addr)), "R2 reg_rdata", reg_rdata, ref_read(int'(reg_addr)));
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(int a, bit [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(int a, bit [31:0] exp, string tag);
    @(negedge clk);
    reg_addr = AW'(a);
    #1;
    check(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic send(bit [28:0] id, bit ext, bit rtr, bit acc, bit fifo, int idx, string tag);
    @(negedge clk);
    frm_valid = 1; frm_id = id; frm_ext = ext; frm_rtr = rtr;
    @(negedge clk);
    frm_valid = 0;
    #1;
    check(hit_valid == 1'b1, {tag, " strobe R12"}, hit_valid, 1);
    check(hit_accept == acc, {tag, " accept"}, hit_accept, acc);
    check(hit_fifo == fifo, {tag, " fifo"}, hit_fifo, fifo);
    check(int'(hit_index) == idx, {tag, " index"}, hit_index, idx);
  endtask

  bit [28:0] p_id  [8];
  bit        p_ext [8];
  bit        p_rtr [8];

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(hit_valid == 0 && hit_accept == 0 && hit_fifo == 0 && hit_index == 0,
          "R1 outputs in reset", {hit_valid, hit_accept, hit_fifo}, 0);
    rst_n = 1;
    for (int a = 0; a < 5; a++) rd(a, 0, "R1 control reset");
    rd(16, 0, "R1 word reset");
    rd(43, 0, "R1 word reset");

    // R3: gated control writes
    wr(1, 32'h3FFF);
    rd(1, 0, "R3 layout write ignored without cfg");
    wr(3, 32'h3FFF);
    rd(3, 0, "R3 fifo write ignored without cfg");
    wr(0, 1);
    wr(1, 32'hFFFF_FFFF);
    rd(1, 32'h3FFF, "R2 reserved layout bits zero");
    wr(1, 0);
    wr(0, 0);
    wr(10, 32'h1234);
    rd(10, 0, "R2 unmapped address reads zero");

    // R4: word write gating
    wr(4, 32'h1);
    wr(16, 32'hAAAA_5555);
    rd(16, 0, "R4 enabled bank word locked");
    wr(18, 32'h1357_9BDF);
    rd(18, 32'h1357_9BDF, "R4 disabled bank word written");
    wr(0, 1);
    wr(16, 32'hAAAA_5555);
    rd(16, 32'hAAAA_5555, "R4 cfg bit unlocks enabled bank");
    wr(4, 0);

    // directed filter setup under cfg
    wr(20, 32'h2460_0000); wr(21, 32'hD5E6_F784);  // bank2 32 list
    wr(22, 32'h2400_0000); wr(23, 32'hFF80_0000);  // bank3 32 mask
    wr(26, 32'h0A20_0A00); wr(27, 32'h0A60_0A40);  // bank5 16 list
    wr(28, 32'h6000_0FF8); wr(29, 32'hFFFF_FFFF);  // bank6 32 list
    wr(30, 32'hFFE0_8000); wr(31, 32'hFFFF_FFFF);  // bank7 16 mask
    wr(1, 32'h4C);
    wr(2, 32'h64);
    wr(3, 32'h28);
    wr(0, 0);
    wr(4, 32'hEC);

    send(29'h123, 0, 0, 1, 0, 8,  "R10 lowest bank wins");
    send(29'h122, 0, 0, 1, 1, 12, "R7 mask match R11");
    send(29'h1ABCDEF0, 1, 0, 1, 0, 9, "R6 extended list slot1");
    send(29'h1ABCDEF1, 1, 0, 0, 0, 0, "R6 extended mismatch");
    send(29'h052, 0, 0, 1, 1, 22, "R8 16-bit list slot2");
    send(29'h123, 0, 1, 1, 1, 12, "R7 remote flag masked out");
    send(29'h300, 0, 0, 1, 0, 24, "R9 standard ignores extended bits");
    send(29'h400, 0, 1, 1, 0, 28, "R8 16-bit mask");
    wr(4, 32'hE8);
    send(29'h123, 0, 0, 1, 1, 12, "R5 disabled bank skipped");
    wr(4, 0);
    send(29'h123, 0, 0, 0, 0, 0, "R5 all banks disabled");

    // randomized phase checked by the model every clock
    for (int i = 0; i < 8; i++) begin
      p_id[i]  = 29'($urandom);
      p_ext[i] = 1'($urandom);
      p_rtr[i] = 1'($urandom);
    end
    for (int n = 0; n < 4000; n++) begin
      int k;
      int j;
      int sel;
      @(negedge clk);
      k = int'($urandom_range(7));
      j = int'($urandom_range(7));
      reg_we = ($urandom_range(3) == 0);
      sel = int'($urandom_range(9));
      if (sel < 3) reg_addr = AW'($urandom_range(4));
      else if (sel < 9) reg_addr = AW'(16 + $urandom_range(2*NB - 1));
      else reg_addr = AW'($urandom);
      case ($urandom_range(3))
        0: reg_wdata = mk32(p_id[k], p_ext[k], p_rtr[k]);
        1: reg_wdata = {mk16(p_id[k], p_ext[k], p_rtr[k]), mk16(p_id[j], p_ext[j], p_rtr[j])};
        2: reg_wdata = {16'($urandom), mk16(p_id[j], p_ext[j], p_rtr[j])};
        default: reg_wdata = $urandom;
      endcase
      frm_valid = 1'($urandom);
      frm_id = p_id[j]; frm_ext = p_ext[j]; frm_rtr = p_rtr[j];
    end
    @(negedge clk);
    reg_we = 0; frm_valid = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule